// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a shared two-port memory and watches the access controls of both ports: enable, write strobe and address. Two words at the top of the address space serve as mailboxes. The very top word belongs to the right port. The word just below it belongs to the left port. When one port writes into the mailbox owned by the other port, the owner gets an interrupt request. The request stays up until the owner reads its own mailbox.

Nothing moves through this block except access controls. It has no data path and no handshake, so every pin is a plain control or status signal. The memory array and the mailbox data are kept elsewhere. Only the address decode and the two interrupt flags are built here.

The two flags are registered and update on the rising clock edge after the access is sampled. The outputs are active low. The address width is a parameter, and both mailbox addresses are derived from it.

Top module: `mbx_irq_logic`

## Requirements
- R1: While reset is held, and on the first edge after it is released, `l_irq_n` and `r_irq_n` are both 1 (no request).
- R2: A clocked left-port write (`l_en`=1, `l_wr`=1) to address all-ones (the right mailbox) drives `r_irq_n` to 0 from the next cycle on.
- R3: A clocked right-port write to address all-ones minus one (the left mailbox) drives `l_irq_n` to 0 from the next cycle on.
- R4: A left-port read (`l_en`=1, `l_wr`=0) of all-ones minus one returns `l_irq_n` to 1 on the next cycle. A right-port read of all-ones returns `r_irq_n` to 1 on the next cycle.
- R5: A port writing to its own mailbox changes neither flag.
- R6: A port reading the other port's mailbox changes neither flag.
- R7: If a set and a clear for the same flag arrive in the same cycle, the flag ends up set (output 0).
- R8: An access to any non-mailbox address, or any cycle with the port enable low, changes neither flag.
- R9: The two flags are independent. Simultaneous writes to both peer mailboxes set both flags, and simultaneous own-mailbox reads clear both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_addr | input | AW | Left port address |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_addr | input | AW | Right port address |
| l_irq_n | output | 1 | Interrupt request to the left port, active low |
| r_irq_n | output | 1 | Interrupt request to the right port, active low |

## Verification
Raising a flag and clearing that same flag can happen in the same cycle. This occurs when the owner reads its mailbox while the peer writes into it. The bench provokes this by first setting the flag, then driving both ports at once: the owner reads the owner's mailbox while the peer writes to it. The result is judged correct only if the flag is still asserted afterwards. The bench also sweeps every port, enable, direction and address of a 4-bit configuration from all four starting flag states, and compares the outputs against values computed from the mailbox addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;

  typedef struct packed {
    logic rd_own;   // read of the port's own mailbox
    logic wr_peer;  // write into the other port's mailbox
  } mbx_hit_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] OWN_ADDR = '1,
  parameter logic [AW-1:0] PEER_ADDR = '0
) (
  input  logic          en,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output mbx_hit_t      hit
);
  logic own_match;
  logic peer_match;

  always_comb begin
    own_match   = (addr == OWN_ADDR);
    peer_match  = (addr == PEER_ADDR);
    hit.rd_own  = en && !wr && own_match;
    hit.wr_peer = en &&  wr && peer_match;
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_n
);
  logic pending;

  // set wins over clear when both land in one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (set)
      pending <= 1'b1;
    else if (clr)
      pending <= 1'b0;
  end

  assign flag_n = !pending;
endmodule

// File: rtl/mbx_irq_logic.sv
module mbx_irq_logic
  import mbx_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  localparam int unsigned NSIDE = 2;
  localparam logic [AW-1:0] RIGHT_BOX = {AW{1'b1}};
  localparam logic [AW-1:0] LEFT_BOX  = RIGHT_BOX - 1'b1;

  logic          en_v   [NSIDE];
  logic          wr_v   [NSIDE];
  logic [AW-1:0] addr_v [NSIDE];
  mbx_hit_t      hit_v  [NSIDE];
  logic          irq_v  [NSIDE];

  assign en_v[SIDE_LEFT]    = l_en;
  assign wr_v[SIDE_LEFT]    = l_wr;
  assign addr_v[SIDE_LEFT]  = l_addr;
  assign en_v[SIDE_RIGHT]   = r_en;
  assign wr_v[SIDE_RIGHT]   = r_wr;
  assign addr_v[SIDE_RIGHT] = r_addr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [AW-1:0] OWN  = (s == SIDE_LEFT) ? LEFT_BOX  : RIGHT_BOX;
    localparam logic [AW-1:0] PEER = (s == SIDE_LEFT) ? RIGHT_BOX : LEFT_BOX;

    mbx_port_decode #(
      .AW        (AW),
      .OWN_ADDR  (OWN),
      .PEER_ADDR (PEER)
    ) u_dec (
      .en   (en_v[s]),
      .wr   (wr_v[s]),
      .addr (addr_v[s]),
      .hit  (hit_v[s])
    );

    // flag s is raised by the opposite side, cleared by side s
    mbx_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (hit_v[NSIDE-1-s].wr_peer),
      .clr    (hit_v[s].rd_own),
      .flag_n (irq_v[s])
    );
  end

  assign l_irq_n = irq_v[SIDE_LEFT];
  assign r_irq_n = irq_v[SIDE_RIGHT];
endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en,
  input logic          l_wr,
  input logic [AW-1:0] l_addr,
  input logic          r_en,
  input logic          r_wr,
  input logic [AW-1:0] r_addr,
  input logic          l_irq_n,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] RBOX = {AW{1'b1}};
  localparam logic [AW-1:0] LBOX = RBOX - 1'b1;

  logic set_l, set_r, clr_l, clr_r;
  assign set_r = l_en && l_wr && (l_addr == RBOX);
  assign set_l = r_en && r_wr && (r_addr == LBOX);
  assign clr_l = l_en && !l_wr && (l_addr == LBOX);
  assign clr_r = r_en && !r_wr && (r_addr == RBOX);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (l_irq_n && r_irq_n));

  a_r2_left_write_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_r |=> !r_irq_n);

  a_r3_right_write_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_l |=> !l_irq_n);

  a_r4_left_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l && !set_l) |=> l_irq_n);

  a_r4_right_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r && !set_r) |=> r_irq_n);

  a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_l && !clr_l) |=> $stable(l_irq_n));

  a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_r && !clr_r) |=> $stable(r_irq_n));
endmodule

bind mbx_irq_logic mbx_irq_checker #(.AW(AW)) u_mbx_chk (.*);

// File: tb/test_mbx_irq_logic.sv
`timescale 1ns/1ps
module test_mbx_irq_logic;
  localparam int unsigned AW = 4;
  localparam int unsigned NADDR = 1 << AW;
  localparam logic [AW-1:0] RBOX = {AW{1'b1}};
  localparam logic [AW-1:0] LBOX = RBOX - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_wr = 0, r_en = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_irq_logic #(.AW(AW)) i_mbx_irq_logic (.*);

  task automatic check(string req, logic exp_l, logic exp_r);
    n_chk++;
    if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
      n_bad++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
               req, l_irq_n, r_irq_n, exp_l, exp_r);
    end
  endtask

  task automatic cyc(logic le, logic lw, logic [AW-1:0] la,
                     logic re, logic rw, logic [AW-1:0] ra);
    @(negedge clk);
    l_en = le; l_wr = lw; l_addr = la;
    r_en = re; r_wr = rw; r_addr = ra;
    @(negedge clk);
    l_en = 0; r_en = 0;
  endtask

  // bring flags to a known state: lset/rset = request pending
  task automatic set_state(bit lset, bit rset);
    cyc(1, 0, LBOX, 1, 0, RBOX);
    if (lset) cyc(0, 0, '0, 1, 1, LBOX);
    if (rset) cyc(1, 1, RBOX, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b1, 1'b1);

    // sweep: starting state x side x enable x direction x address
    for (int st = 0; st < 4; st++) begin
      for (int side = 0; side < 2; side++) begin
        for (int en = 0; en < 2; en++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int a = 0; a < NADDR; a++) begin
              bit lset = st[0];
              bit rset = st[1];
              bit nl = lset;
              bit nr = rset;
              string tag;
              logic [AW-1:0] ad = a[AW-1:0];
              set_state(lset, rset);
              if (side == 0) cyc(en[0], wr[0], ad, 0, 0, '0);
              else           cyc(0, 0, '0, en[0], wr[0], ad);
              if (en == 1) begin
                if (side == 1 && wr == 1 && ad == LBOX) nl = 1;
                if (side == 0 && wr == 1 && ad == RBOX) nr = 1;
                if (side == 0 && wr == 0 && ad == LBOX) nl = 0;
                if (side == 1 && wr == 0 && ad == RBOX) nr = 0;
              end
              if (en == 0 || (ad != LBOX && ad != RBOX)) tag = "R8";
              else if (wr == 1 && side == 0 && ad == RBOX) tag = "R2";
              else if (wr == 1 && side == 1 && ad == LBOX) tag = "R3";
              else if (wr == 1) tag = "R5";
              else if ((side == 0 && ad == LBOX) || (side == 1 && ad == RBOX)) tag = "R4";
              else tag = "R6";
              check(tag, !nl, !nr);
            end
          end
        end
      end
    end

    // R7: owner read and peer write on the same flag in one cycle
    set_state(1, 0);
    cyc(1, 0, LBOX, 1, 1, LBOX);
    check("R7", 1'b0, 1'b1);
    set_state(0, 0);
    cyc(1, 0, LBOX, 1, 1, LBOX);
    check("R7", 1'b0, 1'b1);
    set_state(0, 1);
    cyc(1, 1, RBOX, 1, 0, RBOX);
    check("R7", 1'b1, 1'b0);

    // R9: both sides at once
    set_state(0, 0);
    cyc(1, 1, RBOX, 1, 1, LBOX);
    check("R9", 1'b0, 1'b0);
    cyc(1, 0, LBOX, 1, 0, RBOX);
    check("R9", 1'b1, 1'b1);
    set_state(1, 1);
    cyc(1, 0, LBOX, 0, 0, '0);
    check("R9", 1'b1, 1'b0);

    // R1: reset in the middle clears pending requests
    set_state(1, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b1, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule